// File: doc/BRIEF.md
# Wide-to-Narrow Slave Width Adapter

This block sits between a 32-bit master port with byte addresses and an 8-bit slave port. It takes one master word access at a time. It turns that access into a series of narrow slave accesses and holds the master stalled until the series has finished. Each access completes in the cycle where its strobe is high and its wait request is low. Slave read data is valid in that same cycle.

A build parameter picks one of two address mappings, so the same narrow slave can look like memory or like a set of registers.

- **Packed mode** suits memory-like slaves. The master byte address plus a lane number gives the slave address. Up to four slave bytes are gathered into one word, or scattered out of one word, in ascending lane order.
- **Register mode** suits register-like slaves. Each master word address maps to one slave location, the master address divided by four. That location sits in the lowest byte lane.

In both modes, slave locations at or above a configured depth are never touched. Their lanes read as zero.

Top module: `wna_width_adapter`

## Requirements
- R1: In packed mode, a read at master address A returns slave byte A+i in data bits 8i+7:8i, for lanes i = 0..3. Slave byte A sits in bits 7:0 and byte A+3 in bits 31:24.
- R2: In packed mode, a lane whose slave address A+i is at or above the depth issues no slave access and reads as zero. With depth 5, a read at address 4 returns byte 4 in bits 7:0 and zero above.
- R3: In register mode, a read at master address A returns slave location A>>2 in bits 7:0 and zero in bits 31:8. Addresses 0, 4 and 8 return locations 0, 1 and 2.
- R4: In register mode, a write stores write-data bits 7:0 at location A>>2 only when byte enable bit 0 is set. Byte enable bits 3:1 and write-data bits 31:8 have no effect.
- R5: In packed mode, a write performs exactly one slave write per byte enable bit i that is set and in range. The write puts write-data bits 8i+7:8i at address A+i, in ascending lane order. Disabled lanes are left unchanged.
- R6: While a master read or write is pending, the master wait request stays high until every slave access of that transfer has completed. It drops for exactly the completion cycle. With no request pending it is low.
- R7: While the slave raises its wait request, the adapter holds the current slave strobe, address and write data unchanged. Results stay correct under random slave stalls.
- R8: In either mode, no slave access is ever issued to an address at or above the depth. A register-mode read beyond the depth returns zero.
- R9: After reset the master wait request is low, both slave strobes are low and the master read data is zero.
- R10: A slave read is issued only during a master read, and a slave write only during a master write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mAddr | input | ADDR_W | Master byte address |
| mRead | input | 1 | Master read request, held until accepted |
| mWrite | input | 1 | Master write request, held until accepted |
| mWriteData | input | 32 | Master write data |
| mByteEn | input | 4 | Master byte enables, bit i for bits 8i+7:8i |
| mReadData | output | 32 | Assembled read data, valid when the transfer completes |
| mWaitReq | output | 1 | Stall to the master |
| sAddr | output | ADDR_W | Slave location address |
| sRead | output | 1 | Slave read strobe |
| sWrite | output | 1 | Slave write strobe |
| sWriteData | output | 8 | Slave write data |
| sReadData | input | 8 | Slave read data, valid with an accepted read |
| sWaitReq | input | 1 | Slave stall |

## Verification
The bench builds two copies side by side, both with a 16-bit address and a slave depth of 5. One copy is in packed mode and the other in register mode. A depth of 5 lets a packed read at address 4 fetch one real byte and three empty lanes, and it puts register locations above address 16 out of range. Both out-of-range paths are therefore reached within a few word addresses. Random slave stalls and random byte enables expose the lane ordering and hold behaviour under back-pressure.

// File: rtl/wna_pkg.sv
package wna_pkg;
  localparam int MASTER_W   = 32;
  localparam int SLAVE_W    = 8;
  localparam int LANES      = MASTER_W / SLAVE_W;
  localparam int LANE_IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LANE,
    ST_DONE
  } stateT;

  // strobes from control to datapath
  typedef struct packed {
    logic                  clearAsm;
    logic                  captureLane;
    logic [LANE_IDX_W-1:0] lane;
  } strobeT;
endpackage

// File: rtl/wna_datapath.sv
module wna_datapath
  import wna_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SLAVE_DEPTH = 5,
  parameter bit PACKED      = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  strobeT              strobes,
  input  logic [ADDR_W-1:0]   mAddr,
  input  logic [MASTER_W-1:0] mWriteData,
  input  logic [LANES-1:0]    mByteEn,
  input  logic [SLAVE_W-1:0]  sReadData,
  output logic [ADDR_W-1:0]   sAddr,
  output logic [SLAVE_W-1:0]  sWriteData,
  output logic                laneInRange,
  output logic                laneEnabled,
  output logic [MASTER_W-1:0] mReadData
);
  localparam int EXT_W = ADDR_W + 1;

  logic [EXT_W-1:0]   targetAddr;
  logic [SLAVE_W-1:0] wrBytes  [LANES];
  logic [SLAVE_W-1:0] asmBytes [LANES];

  // address mapping chosen by mode
  generate
    if (PACKED) begin : g_packedMap
      always_comb targetAddr = {1'b0, mAddr} + EXT_W'(strobes.lane);
    end else begin : g_regMap
      always_comb targetAddr = EXT_W'(mAddr >> 2);
    end
  endgenerate

  always_comb begin
    sAddr       = targetAddr[ADDR_W-1:0];
    laneInRange = targetAddr < EXT_W'(SLAVE_DEPTH);
    laneEnabled = mByteEn[strobes.lane];
    sWriteData  = wrBytes[strobes.lane];
  end

  // lane split of write data and join of read data
  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lanes
      assign wrBytes[i] = mWriteData[i*SLAVE_W +: SLAVE_W];
      assign mReadData[i*SLAVE_W +: SLAVE_W] = asmBytes[i];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst || strobes.clearAsm) begin
      for (int i = 0; i < LANES; i++) asmBytes[i] <= '0;
    end else if (strobes.captureLane) begin
      asmBytes[strobes.lane] <= sReadData;
    end
  end
endmodule

// File: rtl/wna_ctrl.sv
module wna_ctrl
  import wna_pkg::*;
#(
  parameter bit PACKED = 1'b1
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   mRead,
  input  logic   mWrite,
  input  logic   laneInRange,
  input  logic   laneEnabled,
  input  logic   sWaitReq,
  output strobeT strobes,
  output logic   sRead,
  output logic   sWrite,
  output logic   mWaitReq
);
  localparam int LAST_LANE = PACKED ? LANES - 1 : 0;

  stateT                 state;
  logic [LANE_IDX_W-1:0] laneIdx;
  logic                  request;
  logic                  inLane;
  logic                  needAccess;
  logic                  laneDone;

  always_comb begin
    request    = mRead || mWrite;
    inLane     = (state == ST_LANE);
    needAccess = laneInRange && (mRead || (mWrite && laneEnabled));
    sRead      = inLane && mRead && laneInRange;
    sWrite     = inLane && !mRead && mWrite && laneInRange && laneEnabled;
    laneDone   = inLane && (!needAccess || !sWaitReq);
    mWaitReq   = request && (state != ST_DONE);

    strobes.clearAsm    = (state == ST_IDLE) && request;
    strobes.captureLane = sRead && !sWaitReq;
    strobes.lane        = laneIdx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      laneIdx <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          laneIdx <= '0;
          if (request) state <= ST_LANE;
        end
        ST_LANE: begin
          if (laneDone) begin
            if (laneIdx == LANE_IDX_W'(LAST_LANE)) state <= ST_DONE;
            else laneIdx <= laneIdx + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wna_width_adapter.sv
module wna_width_adapter
  import wna_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int SLAVE_DEPTH = 5,
  parameter bit PACKED      = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   mAddr,
  input  logic                mRead,
  input  logic                mWrite,
  input  logic [MASTER_W-1:0] mWriteData,
  input  logic [LANES-1:0]    mByteEn,
  output logic [MASTER_W-1:0] mReadData,
  output logic                mWaitReq,
  output logic [ADDR_W-1:0]   sAddr,
  output logic                sRead,
  output logic                sWrite,
  output logic [SLAVE_W-1:0]  sWriteData,
  input  logic [SLAVE_W-1:0]  sReadData,
  input  logic                sWaitReq
);
  strobeT strobes;
  logic   laneInRange;
  logic   laneEnabled;

  wna_ctrl #(.PACKED(PACKED)) ctrl_i (
    .clk(clk), .rst(rst), .mRead(mRead), .mWrite(mWrite),
    .laneInRange(laneInRange), .laneEnabled(laneEnabled), .sWaitReq(sWaitReq),
    .strobes(strobes), .sRead(sRead), .sWrite(sWrite), .mWaitReq(mWaitReq)
  );

  wna_datapath #(.ADDR_W(ADDR_W), .SLAVE_DEPTH(SLAVE_DEPTH), .PACKED(PACKED)) dp_i (
    .clk(clk), .rst(rst), .strobes(strobes), .mAddr(mAddr),
    .mWriteData(mWriteData), .mByteEn(mByteEn), .sReadData(sReadData),
    .sAddr(sAddr), .sWriteData(sWriteData), .laneInRange(laneInRange),
    .laneEnabled(laneEnabled), .mReadData(mReadData)
  );
endmodule

// File: rtl/wna_checker.sv
module wna_checker #(
  parameter int ADDR_W      = 16,
  parameter int SLAVE_DEPTH = 5,
  parameter bit PACKED      = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] mAddr,
  input logic              mRead,
  input logic              mWrite,
  input logic [31:0]       mReadData,
  input logic              mWaitReq,
  input logic [ADDR_W-1:0] sAddr,
  input logic              sRead,
  input logic              sWrite,
  input logic [7:0]        sWriteData,
  input logic              sWaitReq
);
  p_idle_no_wait_r6: assert property (@(posedge clk) disable iff (rst)
    !(mRead || mWrite) |-> !mWaitReq);

  p_slave_stalls_master_r6: assert property (@(posedge clk) disable iff (rst)
    (sRead || sWrite) |-> mWaitReq);

  p_read_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sRead && sWaitReq) |=> (sRead && $stable(sAddr)));

  p_write_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (sWrite && sWaitReq) |=> (sWrite && $stable(sAddr) && $stable(sWriteData)));

  p_in_depth_r8: assert property (@(posedge clk) disable iff (rst)
    (sRead || sWrite) |-> (32'(sAddr) < 32'(SLAVE_DEPTH)));

  p_read_source_r10: assert property (@(posedge clk) disable iff (rst)
    sRead |-> (mRead && !sWrite));

  p_write_source_r10: assert property (@(posedge clk) disable iff (rst)
    sWrite |-> mWrite);

  generate
    if (!PACKED) begin : g_regChecks
      p_reg_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
        (mRead && !mWaitReq) |-> (mReadData[31:8] == 24'd0));

      p_reg_location_r4: assert property (@(posedge clk) disable iff (rst)
        (sRead || sWrite) |-> (sAddr == (mAddr >> 2)));
    end
  endgenerate
endmodule

bind wna_width_adapter wna_checker #(
  .ADDR_W(ADDR_W), .SLAVE_DEPTH(SLAVE_DEPTH), .PACKED(PACKED)
) chk_i (
  .clk(clk), .rst(rst), .mAddr(mAddr), .mRead(mRead), .mWrite(mWrite),
  .mReadData(mReadData), .mWaitReq(mWaitReq), .sAddr(sAddr), .sRead(sRead),
  .sWrite(sWrite), .sWriteData(sWriteData), .sWaitReq(sWaitReq)
);

// File: tb/wna_width_adapter_tb_top.sv
`timescale 1ns/1ps
module wna_width_adapter_tb_top;
  localparam int ADDR_W = 16;
  localparam int DEPTH  = 5;
  localparam int MEMSZ  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [ADDR_W-1:0] mAddr      [2];
  logic              mRead      [2];
  logic              mWrite     [2];
  logic [31:0]       mWriteData [2];
  logic [3:0]        mByteEn    [2];
  logic [31:0]       mReadData  [2];
  logic              mWaitReq   [2];
  logic [ADDR_W-1:0] sAddr      [2];
  logic              sRead      [2];
  logic              sWrite     [2];
  logic [7:0]        sWriteData [2];
  logic [7:0]        sReadData  [2];
  logic              sWaitReq   [2];

  logic [7:0]  slvMem [2][MEMSZ];
  logic [7:0]  expMem [2][MEMSZ];
  logic [15:0] accLog [2][256];
  int          logCnt [2];
  int          oorHits [2];
  bit          stallEn = 1'b0;
  bit          finished = 1'b0;
  int          checks = 0;
  int          errors = 0;

  // index 0: packed mode, index 1: register mode
  wna_width_adapter #(.ADDR_W(ADDR_W), .SLAVE_DEPTH(DEPTH), .PACKED(1'b1)) dut_i (
    .clk(clk), .rst(rst), .mAddr(mAddr[0]), .mRead(mRead[0]), .mWrite(mWrite[0]),
    .mWriteData(mWriteData[0]), .mByteEn(mByteEn[0]), .mReadData(mReadData[0]),
    .mWaitReq(mWaitReq[0]), .sAddr(sAddr[0]), .sRead(sRead[0]), .sWrite(sWrite[0]),
    .sWriteData(sWriteData[0]), .sReadData(sReadData[0]), .sWaitReq(sWaitReq[0])
  );

  wna_width_adapter #(.ADDR_W(ADDR_W), .SLAVE_DEPTH(DEPTH), .PACKED(1'b0)) dut_reg_i (
    .clk(clk), .rst(rst), .mAddr(mAddr[1]), .mRead(mRead[1]), .mWrite(mWrite[1]),
    .mWriteData(mWriteData[1]), .mByteEn(mByteEn[1]), .mReadData(mReadData[1]),
    .mWaitReq(mWaitReq[1]), .sAddr(sAddr[1]), .sRead(sRead[1]), .sWrite(sWrite[1]),
    .sWriteData(sWriteData[1]), .sReadData(sReadData[1]), .sWaitReq(sWaitReq[1])
  );

  function automatic logic [7:0] initByte(int m, int i);
    return 8'(8'h10 + m * 8'h80 + i * 8'h11);
  endfunction

  // slave models
  for (genvar g = 0; g < 2; g++) begin : g_slave
    assign sReadData[g] = slvMem[g][sAddr[g][3:0]];

    always @(posedge clk) begin
      if (rst) begin
        for (int i = 0; i < MEMSZ; i++) slvMem[g][i] <= initByte(g, i);
        sWaitReq[g] <= 1'b0;
        logCnt[g]   <= 0;
        oorHits[g]  <= 0;
      end else begin
        sWaitReq[g] <= stallEn && ($urandom_range(0, 3) == 0);
        if ((sRead[g] || sWrite[g]) && 32'(sAddr[g]) >= DEPTH) oorHits[g] <= oorHits[g] + 1;
        if ((sRead[g] || sWrite[g]) && !sWaitReq[g]) begin
          accLog[g][logCnt[g][7:0]] <= sAddr[g];
          logCnt[g] <= logCnt[g] + 1;
          if (sWrite[g]) slvMem[g][sAddr[g][3:0]] <= sWriteData[g];
        end
      end
    end
  end

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] expRead(int m, logic [15:0] a);
    logic [31:0] r = '0;
    if (m == 0) begin
      for (int i = 0; i < 4; i++)
        if (32'(a) + i < DEPTH) r[i*8 +: 8] = expMem[0][32'(a) + i];
    end else if (32'(a >> 2) < DEPTH) begin
      r[7:0] = expMem[1][32'(a >> 2)];
    end
    return r;
  endfunction

  task automatic runXfer(int m, logic [15:0] a, bit isWrite, logic [31:0] wd,
                         logic [3:0] be, output logic [31:0] rd);
    @(negedge clk);
    mAddr[m] = a; mWriteData[m] = wd; mByteEn[m] = be;
    mRead[m] = !isWrite; mWrite[m] = isWrite;
    do @(negedge clk); while (mWaitReq[m]);
    rd = mReadData[m];
    @(negedge clk);
    mRead[m] = 1'b0; mWrite[m] = 1'b0;
  endtask

  task automatic doRead(int m, logic [15:0] a, string tag);
    logic [31:0] rd;
    logic [31:0] expD;
    int startCnt;
    int expCnt = 0;
    startCnt = logCnt[m];
    expD = expRead(m, a);
    runXfer(m, a, 1'b0, 32'd0, 4'h0, rd);
    check(tag, $sformatf("read data m%0d addr %h", m, a), rd, expD);
    if (m == 0) begin
      for (int i = 0; i < 4; i++) if (32'(a) + i < DEPTH) expCnt++;
    end else if (32'(a >> 2) < DEPTH) expCnt = 1;
    // R6/R2: all slave reads done before completion, none for empty lanes
    check("R6", $sformatf("slave reads done m%0d addr %h", m, a),
          32'(logCnt[m] - startCnt), 32'(expCnt));
  endtask

  task automatic doWrite(int m, logic [15:0] a, logic [31:0] wd, logic [3:0] be, string tag);
    logic [31:0] rd;
    logic [15:0] expAddr [4];
    int expCnt = 0;
    int startCnt;
    int orderBad = 0;
    startCnt = logCnt[m];
    if (m == 0) begin
      for (int i = 0; i < 4; i++)
        if (be[i] && 32'(a) + i < DEPTH) begin
          expAddr[expCnt] = 16'(32'(a) + i);
          expCnt++;
          expMem[0][32'(a) + i] = wd[i*8 +: 8];
        end
    end else if (be[0] && 32'(a >> 2) < DEPTH) begin
      expAddr[0] = a >> 2;
      expCnt = 1;
      expMem[1][32'(a >> 2)] = wd[7:0];
    end
    runXfer(m, a, 1'b1, wd, be, rd);
    check(tag, $sformatf("slave write count m%0d addr %h be %b", m, a, be),
          32'(logCnt[m] - startCnt), 32'(expCnt));
    if (logCnt[m] - startCnt == expCnt)
      for (int k = 0; k < expCnt; k++)
        if (accLog[m][8'(startCnt + k)] != expAddr[k]) orderBad++;
    check(tag, $sformatf("slave write order m%0d addr %h", m, a), 32'(orderBad), 32'd0);
    for (int i = 0; i < DEPTH; i++)
      check(tag, $sformatf("memory m%0d loc %0d", m, i), 32'(slvMem[m][i]), 32'(expMem[m][i]));
  endtask

  initial begin
    for (int m = 0; m < 2; m++) begin
      mAddr[m] = '0; mRead[m] = 1'b0; mWrite[m] = 1'b0;
      mWriteData[m] = '0; mByteEn[m] = '0;
      for (int i = 0; i < MEMSZ; i++) expMem[m][i] = initByte(m, i);
    end
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R9: reset state
    for (int m = 0; m < 2; m++) begin
      check("R9", "wait request after reset", 32'(mWaitReq[m]), 32'd0);
      check("R9", "slave strobes after reset", 32'({sRead[m], sWrite[m]}), 32'd0);
      check("R9", "read data after reset", mReadData[m], 32'd0);
    end

    // packed directed
    doRead(0, 16'h0000, "R1");
    check("R1", "packed word 0 literal", mReadData[0],
          {initByte(0, 3), initByte(0, 2), initByte(0, 1), initByte(0, 0)});
    doRead(0, 16'h0004, "R2");
    check("R2", "packed addr 4 literal", mReadData[0], {24'd0, initByte(0, 4)});
    doRead(0, 16'h0008, "R2");
    doWrite(0, 16'h0000, 32'hA1B2C3D4, 4'b1010, "R5");
    doRead(0, 16'h0000, "R1");
    doWrite(0, 16'h0004, 32'h55667788, 4'b1111, "R5");
    doRead(0, 16'h0004, "R2");

    // register directed
    doRead(1, 16'h0000, "R3");
    doRead(1, 16'h0004, "R3");
    check("R3", "register addr 4 literal", mReadData[1], {24'd0, initByte(1, 1)});
    doRead(1, 16'h0008, "R3");
    doRead(1, 16'h0014, "R8");
    doWrite(1, 16'h0004, 32'hDEADBE77, 4'b0001, "R4");
    doWrite(1, 16'h0008, 32'h12345699, 4'b1110, "R4");
    doRead(1, 16'h0004, "R4");
    doRead(1, 16'h0008, "R4");

    // random with slave stalls
    stallEn = 1'b1;
    for (int n = 0; n < 120; n++) begin
      int m = $urandom_range(0, 1);
      logic [15:0] a = 16'($urandom_range(0, 6) * 4);
      if ($urandom_range(0, 1) == 1)
        doWrite(m, a, $urandom, 4'($urandom), m == 0 ? "R7 R5" : "R7 R4");
      else
        doRead(m, a, m == 0 ? "R7 R1" : "R7 R3");
    end
    stallEn = 1'b0;

    repeat (3) @(negedge clk);
    check("R8", "packed accesses beyond depth", 32'(oorHits[0]), 32'd0);
    check("R8", "register accesses beyond depth", 32'(oorHits[1]), 32'd0);
    check("R6", "no wait request when idle", 32'({mWaitReq[0], mWaitReq[1]}), 32'd0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule